// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block drives up to three periodic pulse lines that stay phase-locked to a free-running time-of-day value. The pulse trains do not run on their own. Software first loads a 64-bit alarm value, normally a whole second minus one nominal tick and at least half a second ahead of the current time. The trains start together once the time value reaches that alarm. After that, each line repeats at its own programmed interval. The period register for each line holds the wanted interval minus one nominal tick. Every cycle the block adds the nominal tick to a per-line elapsed-time accumulator and fires a pulse when the accumulator reaches the register value.

A three-state controller sequences the block. The states are IDLE, ARMED and RUN. The ARM transition (alarm high-word write) goes from IDLE, ARMED or RUN to ARMED. The LAUNCH transition goes from ARMED to RUN when the time has reached the alarm and the start-enable bit is set. The DISARM transition goes from ARMED or RUN to IDLE on a write of a period register or of the alarm low word. Every pulse of line 0 also sets a sticky event flag. The flag is cleared by writing one and can be routed to an interrupt through a mask bit.

Register writes use one port. The address map is: 0 control (bit 0 start enable), 1 event (bit 0, write one to clear), 2 mask (bit 0), 3 alarm low word, 4 alarm high word, 5+i period of line i.

Top module: `pulse_alarm_gen`

## Requirements
- R1: The alarm is 64 bits. Writing address 3 loads bits 31:0 and takes the block to IDLE. Writing address 4 loads bits 63:32 and takes the block to ARMED. A high word that puts the alarm out of reach prevents any start.
- R2: In ARMED the block launches on the first clock edge where time_now is greater than or equal to the alarm. A time value that steps over the exact alarm still launches.
- R3: Launch needs control bit 0 (start enable) to be set. While it is clear, an ARMED block stays ARMED and no pulse appears. Setting it later launches on the next edge if the alarm has already been reached.
- R4: On launch, every present pulse line goes high in the cycle that follows the launching edge.
- R5: While in RUN, line i pulses every (period_i + nom_period) time units. Each pulse is one clock cycle wide whenever period_i is nonzero.
- R6: NUM_PULSE (2 or 3) sets the number of lines. A write to the period address of an absent line is ignored and does not disarm.
- R7: Each pulse of line 0 sets the event flag (address 1, bit 0) one cycle later.
- R8: irq_o is high exactly when the event flag and mask bit 0 are both set.
- R9: Writing address 1 with bit 0 set clears the event flag. Writing it with bit 0 clear leaves the flag unchanged.
- R10: Writing any present period register takes the block to IDLE. No further pulses appear until the next alarm launch.
- R11: After reset the block is IDLE, all pulse lines are low, and the event flag, mask and start enable are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current time value from the time counter |
| nom_period | input | NOM_W | Nominal tick added to the time per clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| pulse_o | output | NUM_PULSE | Periodic pulse lines |
| evt_o | output | 1 | Sticky line-0 pulse event flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The properties assume that time_now advances by nom_period on every clock and never goes backward. They also assume nom_period is nonzero and that at most one register write arrives per cycle, with the alarm low word written before the high word. The stimulus keeps within these limits. Its time source steps by exactly one 8-unit tick per clock, all intervals are whole multiples of that tick, and each write is a single-cycle strobe issued from one task. Alarms are placed either well ahead of the running time or deliberately in the past, so that the expected launch edge follows from the tick grid alone.

// File: rtl/pag_pkg.sv
package pag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } gen_state_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_EVENT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd2;
    localparam logic [ADDR_W-1:0] A_ALM_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_ALM_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_PER0   = 3'd5;

endpackage

// File: rtl/pag_regs.sv
module pag_regs
    import pag_pkg::*;
#(
    parameter int NUM_PULSE = 3,
    parameter int PER_W     = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [31:0]                     wr_data,
    input  logic                            pulse0,
    output logic                            start_en,
    output logic                            mask_bit,
    output logic                            evt_flag,
    output logic [63:0]                     alarm,
    output logic [NUM_PULSE-1:0][PER_W-1:0] period,
    output logic                            arm_req,
    output logic                            disarm_req
);

    logic [NUM_PULSE-1:0] per_hit;

    // Control, mask and alarm words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_en <= 1'b0;
            mask_bit <= 1'b0;
            alarm    <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL)   start_en     <= wr_data[0];
            if (wr_addr == A_MASK)   mask_bit     <= wr_data[0];
            if (wr_addr == A_ALM_LO) alarm[31:0]  <= wr_data;
            if (wr_addr == A_ALM_HI) alarm[63:32] <= wr_data;
        end
    end

    // Sticky event: a new pulse wins over a clearing write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            evt_flag <= 1'b0;
        else if (pulse0)
            evt_flag <= 1'b1;
        else if (wr_en && wr_addr == A_EVENT && wr_data[0])
            evt_flag <= 1'b0;
    end

    // One period register per present line
    for (genvar i = 0; i < NUM_PULSE; i++) begin : g_per
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_PER0) + i);

        assign per_hit[i] = wr_en && (wr_addr == MY_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                period[i] <= '0;
            else if (per_hit[i])
                period[i] <= wr_data[PER_W-1:0];
        end
    end

    assign arm_req    = wr_en && (wr_addr == A_ALM_HI);
    assign disarm_req = (wr_en && (wr_addr == A_ALM_LO)) || (|per_hit);

endmodule

// File: rtl/pag_fsm.sv
module pag_fsm
    import pag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_req,
    input  logic       disarm_req,
    input  logic       match,
    input  logic       start_en,
    output gen_state_t state,
    output logic       launch,
    output logic       running
);

    gen_state_t state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Transitions: ARM, LAUNCH, DISARM
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (arm_req) state_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (disarm_req)             state_nxt = ST_IDLE;
                else if (arm_req)           state_nxt = ST_ARMED;
                else if (match && start_en) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (disarm_req)   state_nxt = ST_IDLE;
                else if (arm_req) state_nxt = ST_ARMED;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        launch  = (state == ST_ARMED) && !disarm_req && !arm_req
                  && match && start_en;
        running = (state == ST_RUN);
    end

endmodule

// File: rtl/pag_channel.sv
module pag_channel #(
    parameter int PER_W = 32,
    parameter int NOM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             running,
    input  logic [NOM_W-1:0] nom,
    input  logic [PER_W-1:0] period,
    output logic             pulse
);

    localparam int ACC_W = PER_W + 1;

    // Elapsed time since the last pulse, counted after the current tick
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] per_ext;
    logic [ACC_W-1:0] nom_ext;

    assign per_ext = ACC_W'(period);
    assign nom_ext = ACC_W'(nom);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            pulse <= 1'b0;
        end else if (launch) begin
            acc   <= '0;
            pulse <= 1'b1;
        end else if (running) begin
            if (acc >= per_ext) begin
                acc   <= acc - per_ext;
                pulse <= 1'b1;
            end else begin
                acc   <= acc + nom_ext;
                pulse <= 1'b0;
            end
        end else begin
            acc   <= '0;
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/pulse_alarm_gen.sv
module pulse_alarm_gen
    import pag_pkg::*;
#(
    parameter int NUM_PULSE = 3,
    parameter int PER_W     = 32,
    parameter int NOM_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [63:0]          time_now,
    input  logic [NOM_W-1:0]     nom_period,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [31:0]          wr_data,
    output logic [NUM_PULSE-1:0] pulse_o,
    output logic                 evt_o,
    output logic                 irq_o
);

    logic                            start_en;
    logic                            mask_q;
    logic [63:0]                     alarm_q;
    logic [NUM_PULSE-1:0][PER_W-1:0] period_q;
    logic                            arm_req;
    logic                            disarm_req;
    logic                            match;
    logic                            launch;
    logic                            running;
    gen_state_t                      state_q;

    pag_regs #(
        .NUM_PULSE (NUM_PULSE),
        .PER_W     (PER_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pulse0     (pulse_o[0]),
        .start_en   (start_en),
        .mask_bit   (mask_q),
        .evt_flag   (evt_o),
        .alarm      (alarm_q),
        .period     (period_q),
        .arm_req    (arm_req),
        .disarm_req (disarm_req)
    );

    // Greater-or-equal so a tick stepping over the exact value still fires
    assign match = (time_now >= alarm_q);

    pag_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_req    (arm_req),
        .disarm_req (disarm_req),
        .match      (match),
        .start_en   (start_en),
        .state      (state_q),
        .launch     (launch),
        .running    (running)
    );

    for (genvar i = 0; i < NUM_PULSE; i++) begin : g_ch
        pag_channel #(
            .PER_W (PER_W),
            .NOM_W (NOM_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .launch  (launch),
            .running (running),
            .nom     (nom_period),
            .period  (period_q[i]),
            .pulse   (pulse_o[i])
        );
    end

    assign irq_o = evt_o & mask_q;

endmodule

// File: rtl/pag_checker.sv
module pag_checker
    import pag_pkg::*;
#(
    parameter int NUM_PULSE = 3,
    parameter int PER_W     = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input gen_state_t                      state,
    input logic                            start_en,
    input logic                            mask_q,
    input logic                            wr_en,
    input logic [2:0]                      wr_addr,
    input logic [NUM_PULSE-1:0]            pulse_o,
    input logic [NUM_PULSE-1:0][PER_W-1:0] period_q,
    input logic                            evt_o,
    input logic                            irq_o
);

    assert_launch_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_ARMED) |-> $past(start_en));

    assert_period_write_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PER0) |=> (state == ST_IDLE));

    assert_alarm_lo_disarms_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_ALM_LO) |=> (state == ST_IDLE));

    assert_pulse_after_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_o) |-> ($past(state) != ST_IDLE));

    assert_event_from_line0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_o) |-> $past(pulse_o[0]));

    assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_q && evt_o));

    for (genvar i = 0; i < NUM_PULSE; i++) begin : g_w
        assert_single_cycle_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_o[i] && period_q[i] != '0 && !wr_en) |=> !pulse_o[i]);
    end

endmodule

bind pulse_alarm_gen pag_checker #(
    .NUM_PULSE (NUM_PULSE),
    .PER_W     (PER_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .start_en (start_en),
    .mask_q   (mask_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .pulse_o  (pulse_o),
    .period_q (period_q),
    .evt_o    (evt_o),
    .irq_o    (irq_o)
);

// File: tb/pulse_alarm_gen_test.sv
`timescale 1ns/1ps
module pulse_alarm_gen_test;

    localparam int  NP  = 3;
    localparam int  NOM = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tcnt = '0;
    logic [63:0] time_now;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [NP-1:0] pulse_o;
    logic        evt_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // Time source: one nominal tick per clock, changed away from the rising edge
    always @(negedge clk) tcnt <= tcnt + 64'd1;
    assign time_now = tcnt * 64'(NOM);

    pulse_alarm_gen #(.NUM_PULSE(NP), .PER_W(32), .NOM_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_now   (time_now),
        .nom_period (8'(NOM)),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pulse_o    (pulse_o),
        .evt_o      (evt_o),
        .irq_o      (irq_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Compare every line against the expected tick grid for n cycles
    task automatic watch(input longint first, input int n, input int iv0,
                         input int iv1, input int iv2, input bit run,
                         input bit chk_evt, input string req);
        int miss [3] = '{0, 0, 0};
        int ivs  [3];
        bit seen0 = 0;
        bit pend = 0;
        ivs[0] = iv0; ivs[1] = iv1; ivs[2] = iv2;
        for (int c = 0; c < n; c++) begin
            longint t;
            @(negedge clk); #1;
            t = longint'(time_now);
            if (pend) begin
                chk(evt_o === 1'b1, "R7", "event after first line0 pulse", evt_o, 1);
                pend = 0;
            end
            for (int ch = 0; ch < NP; ch++) begin
                bit e;
                e = run && (t >= first) && (((t - first) % ivs[ch]) == 0);
                if (pulse_o[ch] !== e) miss[ch]++;
                if (ch == 0 && e && chk_evt && !seen0) begin
                    chk(evt_o === 1'b0, "R7", "event before first pulse", evt_o, 0);
                    seen0 = 1; pend = 1;
                end
            end
        end
        for (int ch = 0; ch < NP; ch++)
            chk(miss[ch] == 0, req, $sformatf("line %0d grid mismatches", ch), miss[ch], 0);
    endtask

    task automatic t_reset;
        chk(pulse_o === '0, "R11", "pulses after reset", pulse_o, 0);
        chk(evt_o === 1'b0, "R11", "event after reset", evt_o, 0);
        chk(irq_o === 1'b0, "R11", "irq after reset", irq_o, 0);
    endtask

    task automatic arm_at(input longint a);
        wr(3'd3, a[31:0]);
        wr(3'd4, a[63:32]);
    endtask

    // R4 R5 R6: aligned alarm, three lines with distinct intervals
    task automatic t_basic;
        longint a;
        wr(3'd0, 32'd1);
        wr(3'd5, 32'd32);
        wr(3'd6, 32'd72);
        wr(3'd7, 32'd16);
        a = ((longint'(time_now) + 160) / NOM) * NOM;
        arm_at(a);
        watch(a + NOM, 60, 40, 80, 24, 1, 1, "R4_R5_R6");
        chk(irq_o === 1'b0, "R8", "irq with mask clear", irq_o, 0);
    endtask

    // R8 R9 R10
    task automatic t_event;
        wr(3'd2, 32'd1);
        chk(irq_o === 1'b1, "R8", "irq with mask set", irq_o, 1);
        wr(3'd5, 32'd32);
        watch(0, 15, 40, 80, 24, 0, 0, "R10");
        chk(evt_o === 1'b1, "R10", "event stays after disarm", evt_o, 1);
        wr(3'd1, 32'd0);
        chk(evt_o === 1'b1, "R9", "write zero keeps event", evt_o, 1);
        wr(3'd1, 32'd1);
        chk(evt_o === 1'b0, "R9", "write one clears event", evt_o, 0);
        chk(irq_o === 1'b0, "R8", "irq after clear", irq_o, 0);
    endtask

    // R2: alarm off the tick grid is stepped over
    task automatic t_skip;
        longint a, g;
        wr(3'd5, 32'd24);
        wr(3'd6, 32'd8);
        wr(3'd7, 32'd40);
        a = ((longint'(time_now) + 120) / NOM) * NOM + 3;
        g = ((a + NOM - 1) / NOM) * NOM;
        arm_at(a);
        watch(g + NOM, 45, 32, 16, 48, 1, 0, "R2");
    endtask

    // R3: start enable gates the launch
    task automatic t_nostart;
        longint a, t;
        wr(3'd0, 32'd0);
        wr(3'd5, 32'd32);
        a = ((longint'(time_now) + 80) / NOM) * NOM;
        arm_at(a);
        watch(0, 30, 40, 16, 48, 0, 0, "R3");
        wr(3'd0, 32'd1);
        t = longint'(time_now);
        watch(t + NOM, 30, 40, 16, 48, 1, 0, "R3");
    endtask

    // R1: high word participates; low word write disarms
    task automatic t_far;
        longint t;
        wr(3'd3, 32'd16);
        wr(3'd4, 32'd1);
        watch(0, 30, 40, 16, 48, 0, 0, "R1");
        wr(3'd4, 32'd0);
        t = longint'(time_now);
        watch(t + NOM, 30, 40, 16, 48, 1, 0, "R1");
        wr(3'd3, 32'd16);
        watch(0, 20, 40, 16, 48, 0, 0, "R1");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        t_reset;
        t_basic;
        t_event;
        t_skip;
        t_nostart;
        t_far;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule